// File: doc/BRIEF.md
# Unified data-space access router

This block sits between a CPU's load/store port and the several stores that share one 16-bit byte-addressed data space. Each request is decoded into one target: the working register file, the I/O register window, internal SRAM, an optional data EEPROM window, or an external memory bus. The router presents the offset that target expects and returns the selected byte to the CPU. Register and I/O locations reached this way behave as plain memory bytes. Internal regions always take priority over the external bus: an address that lands inside an internal region never shows up on the external bus.

A static layout input picks one of two address maps. The compact layout puts the working registers first, then the I/O window, then SRAM. The wide layout drops the working registers from the data space, gives the I/O window the bottom 4 KB, may expose the data EEPROM in the next 4 KB, and starts SRAM at 0x2000. In both layouts everything above the end of internal SRAM goes to the external bus, which carries the full byte address. A 16-bit value stored there as two byte stores keeps its low byte at the lower address.

The CPU holds a request for one cycle. An internal access returns ready in the following cycle, so it takes two cycles in total. An external access holds ready low until the bus acknowledges and a programmable minimum number of wait states has passed.

Top module: `dsr_router`

## Requirements
- R1: With `ext_layout`=0, addresses 0x0000–0x001F strobe `reg_sel`, and `reg_idx` equals address bits [4:0].
- R2: With `ext_layout`=0, addresses 0x0020–0x005F strobe `io_sel` with `io_addr` = address − 0x20. Addresses 0x0060 to 0x0060+SRAM_BYTES−1 strobe `ram_sel` with `ram_addr` = address − 0x60.
- R3: With `ext_layout`=1, addresses 0x0000–0x0FFF strobe `io_sel` with `io_addr` = address. `reg_sel` is never asserted in this layout.
- R4: With `ext_layout`=1, addresses 0x1000–0x1FFF strobe `eep_sel` with `eep_addr` = address − 0x1000 when `eep_map_en`=1. When `eep_map_en`=0, these addresses raise no strobe, reads return 0x00 and writes change nothing.
- R5: With `ext_layout`=1, addresses 0x2000 to 0x2000+SRAM_BYTES−1 strobe `ram_sel` with `ram_addr` = address − 0x2000.
- R6: In each layout, every address at or above the end of internal SRAM strobes `ext_sel`, and `ext_addr` carries the full CPU address. No address inside an internal region ever strobes `ext_sel`.
- R7: An access that does not go to the external bus, including one to the disabled EEPROM window, asserts `cpu_ready` for exactly one cycle. That cycle directly follows the cycle in which `cpu_req` was sampled, so the access takes 2 cycles.
- R8: An external access completes only in a cycle where `ext_ack` is high, and no earlier than `ext_wait` (0–3) cycles after `ext_sel` rises. With `ext_wait`=0 and an immediate acknowledge, it takes 2 cycles.
- R9: At most one of the five target strobes is high in any cycle. A store writes `cpu_wdata` to the addressed byte, and a load returns the addressed byte on `cpu_rdata` in the cycle in which `cpu_ready` is high.
- R10: While `rst` is high, and in the cycle after it, `cpu_ready` and every target strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_layout | input | 1 | 0 = compact layout, 1 = wide layout (static) |
| eep_map_en | input | 1 | Enables the EEPROM window in the wide layout |
| ext_wait | input | 2 | Minimum wait states for external accesses |
| cpu_req | input | 1 | One-cycle access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 8 | Store data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | 8 | Load data, valid with cpu_ready |
| reg_sel | output | 1 | Register file strobe |
| reg_we | output | 1 | Register file write |
| reg_idx | output | 5 | Register index |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data |
| io_sel | output | 1 | I/O window strobe |
| io_we | output | 1 | I/O write |
| io_addr | output | 12 | I/O offset |
| io_wdata | output | 8 | I/O write data |
| io_rdata | input | 8 | I/O read data |
| ram_sel | output | 1 | SRAM strobe |
| ram_we | output | 1 | SRAM write |
| ram_addr | output | RAM_AW | SRAM offset |
| ram_wdata | output | 8 | SRAM write data |
| ram_rdata | input | 8 | SRAM read data |
| eep_sel | output | 1 | EEPROM window strobe |
| eep_we | output | 1 | EEPROM window write |
| eep_addr | output | 12 | EEPROM offset |
| eep_wdata | output | 8 | EEPROM write data |
| eep_rdata | input | 8 | EEPROM read data |
| ext_sel | output | 1 | External bus strobe, held until completion |
| ext_we | output | 1 | External write |
| ext_addr | output | 16 | External byte address |
| ext_wdata | output | 8 | External write data |
| ext_rdata | input | 8 | External read data |
| ext_ack | input | 1 | External acknowledge |

## Verification
The following properties are checked on every cycle:
- At most one strobe is high at a time.
- An internal strobe always coincides with ready, and ready never lasts two cycles.
- External completion requires an acknowledge and the minimum wait count.
- No external strobe carries an address that internal regions shadow.
- The register file is never reached in the wide layout.
- The EEPROM strobe appears only when the window is enabled.

Only the bench's scenarios can show the following:
- Which target and offset each boundary address reaches.
- That stored bytes read back.
- That writes to the disabled window vanish.
- The exact cycle counts produced by each combination of wait setting and acknowledge delay.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    localparam int DW = 8;
    localparam int AW = 16;

    localparam int REG_END   = 32'h0020;
    localparam int CIO_END   = 32'h0060;
    localparam int XIO_END   = 32'h1000;
    localparam int XEEP_END  = 32'h2000;
    localparam int N_TGT     = 6;

    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_REG  = 3'd1,
        TGT_IO   = 3'd2,
        TGT_RAM  = 3'd3,
        TGT_EEP  = 3'd4,
        TGT_EXT  = 3'd5
    } tgt_e;

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_ACCESS = 1'b1
    } phase_e;

    typedef struct packed {
        tgt_e            tgt;
        logic [AW-1:0]   off;
    } route_t;

    typedef struct packed {
        logic            active;
        route_t          route;
        logic            we;
        logic [DW-1:0]   wdata;
    } xfer_t;

    // Map a byte address to its target and region offset.
    function automatic route_t route_addr(input logic [AW-1:0] a,
                                          input logic          wide,
                                          input logic          eep_en,
                                          input int unsigned   ram_bytes);
        int unsigned ai;
        route_t      r;
        ai    = 32'(a);
        r.tgt = TGT_EXT;
        r.off = a;
        if (!wide) begin
            if (ai < REG_END) begin
                r.tgt = TGT_REG;
                r.off = a;
            end else if (ai < CIO_END) begin
                r.tgt = TGT_IO;
                r.off = a - 16'h0020;
            end else if (ai < CIO_END + ram_bytes) begin
                r.tgt = TGT_RAM;
                r.off = a - 16'h0060;
            end
        end else begin
            if (ai < XIO_END) begin
                r.tgt = TGT_IO;
                r.off = a;
            end else if (ai < XEEP_END) begin
                r.tgt = eep_en ? TGT_EEP : TGT_NONE;
                r.off = a - 16'h1000;
            end else if (ai < XEEP_END + ram_bytes) begin
                r.tgt = TGT_RAM;
                r.off = a - 16'h2000;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/dsr_decoder.sv
module dsr_decoder
    import dsr_pkg::*;
#(
    parameter int SRAM_BYTES = 1024
) (
    input  logic [AW-1:0] addr,
    input  logic          wide,
    input  logic          eep_en,
    output route_t        route
);
    always_comb begin
        route = route_addr(addr, wide, eep_en, SRAM_BYTES);
    end
endmodule

// File: rtl/dsr_sequencer.sv
module dsr_sequencer
    import dsr_pkg::*;
#(
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [DW-1:0]     cpu_wdata,
    input  route_t            route_in,
    input  logic [WAIT_W-1:0] ext_wait,
    input  logic              ext_ack,
    output xfer_t             xfer,
    output logic              cpu_ready
);
    phase_e            phase_q;
    route_t            route_q;
    logic              we_q;
    logic [DW-1:0]     wdata_q;
    logic [WAIT_W-1:0] wcnt_q;
    logic              done;

    // Internal targets finish at once; the external bus needs the
    // wait counter drained and an acknowledge in the same cycle.
    always_comb begin
        done = 1'b1;
        if (route_q.tgt == TGT_EXT) begin
            done = (wcnt_q == '0) && ext_ack;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            route_q <= '{tgt: TGT_NONE, off: '0};
            we_q    <= 1'b0;
            wdata_q <= '0;
            wcnt_q  <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (cpu_req) begin
                        phase_q <= PH_ACCESS;
                        route_q <= route_in;
                        we_q    <= cpu_we;
                        wdata_q <= cpu_wdata;
                        wcnt_q  <= ext_wait;
                    end
                end
                PH_ACCESS: begin
                    if (wcnt_q != '0) begin
                        wcnt_q <= wcnt_q - 1'b1;
                    end
                    if (done) begin
                        phase_q <= PH_IDLE;
                        we_q    <= 1'b0;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign cpu_ready   = (phase_q == PH_ACCESS) && done;
    assign xfer.active = (phase_q == PH_ACCESS);
    assign xfer.route  = route_q;
    assign xfer.we     = we_q;
    assign xfer.wdata  = wdata_q;
endmodule

// File: rtl/dsr_target_mux.sv
module dsr_target_mux
    import dsr_pkg::*;
#(
    parameter int RAM_AW = 10
) (
    input  xfer_t             xfer,
    input  logic [DW-1:0]     reg_rdata,
    input  logic [DW-1:0]     io_rdata,
    input  logic [DW-1:0]     ram_rdata,
    input  logic [DW-1:0]     eep_rdata,
    input  logic [DW-1:0]     ext_rdata,
    output logic [N_TGT-1:0]  sel_vec,
    output logic [4:0]        reg_idx,
    output logic [11:0]       io_addr,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [11:0]       eep_addr,
    output logic [AW-1:0]     ext_addr,
    output logic [DW-1:0]     cpu_rdata
);
    // One strobe per target code; code 0 (no target) never strobes.
    assign sel_vec[0] = 1'b0;
    for (genvar t = 1; t < N_TGT; t++) begin : g_sel
        assign sel_vec[t] = xfer.active && (xfer.route.tgt == tgt_e'(t));
    end

    assign reg_idx  = xfer.route.off[4:0];
    assign io_addr  = xfer.route.off[11:0];
    assign ram_addr = xfer.route.off[RAM_AW-1:0];
    assign eep_addr = xfer.route.off[11:0];
    assign ext_addr = xfer.route.off;

    always_comb begin
        case (xfer.route.tgt)
            TGT_REG: cpu_rdata = reg_rdata;
            TGT_IO:  cpu_rdata = io_rdata;
            TGT_RAM: cpu_rdata = ram_rdata;
            TGT_EEP: cpu_rdata = eep_rdata;
            TGT_EXT: cpu_rdata = ext_rdata;
            default: cpu_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dsr_router.sv
module dsr_router
    import dsr_pkg::*;
#(
    parameter int   SRAM_BYTES = 1024,
    parameter int   WAIT_W     = 2,
    localparam int  RAM_AW     = $clog2(SRAM_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_layout,
    input  logic              eep_map_en,
    input  logic [WAIT_W-1:0] ext_wait,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic              cpu_ready,
    output logic [7:0]        cpu_rdata,
    output logic              reg_sel,
    output logic              reg_we,
    output logic [4:0]        reg_idx,
    output logic [7:0]        reg_wdata,
    input  logic [7:0]        reg_rdata,
    output logic              io_sel,
    output logic              io_we,
    output logic [11:0]       io_addr,
    output logic [7:0]        io_wdata,
    input  logic [7:0]        io_rdata,
    output logic              ram_sel,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata,
    output logic              eep_sel,
    output logic              eep_we,
    output logic [11:0]       eep_addr,
    output logic [7:0]        eep_wdata,
    input  logic [7:0]        eep_rdata,
    output logic              ext_sel,
    output logic              ext_we,
    output logic [15:0]       ext_addr,
    output logic [7:0]        ext_wdata,
    input  logic [7:0]        ext_rdata,
    input  logic              ext_ack
);
    route_t            route_d;
    xfer_t             xfer;
    logic [N_TGT-1:0]  sel_vec;

    dsr_decoder #(.SRAM_BYTES(SRAM_BYTES)) dec_i (
        .addr   (cpu_addr),
        .wide   (ext_layout),
        .eep_en (eep_map_en),
        .route  (route_d)
    );

    dsr_sequencer #(.WAIT_W(WAIT_W)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_wdata (cpu_wdata),
        .route_in  (route_d),
        .ext_wait  (ext_wait),
        .ext_ack   (ext_ack),
        .xfer      (xfer),
        .cpu_ready (cpu_ready)
    );

    dsr_target_mux #(.RAM_AW(RAM_AW)) mux_i (
        .xfer      (xfer),
        .reg_rdata (reg_rdata),
        .io_rdata  (io_rdata),
        .ram_rdata (ram_rdata),
        .eep_rdata (eep_rdata),
        .ext_rdata (ext_rdata),
        .sel_vec   (sel_vec),
        .reg_idx   (reg_idx),
        .io_addr   (io_addr),
        .ram_addr  (ram_addr),
        .eep_addr  (eep_addr),
        .ext_addr  (ext_addr),
        .cpu_rdata (cpu_rdata)
    );

    assign reg_sel   = sel_vec[TGT_REG];
    assign io_sel    = sel_vec[TGT_IO];
    assign ram_sel   = sel_vec[TGT_RAM];
    assign eep_sel   = sel_vec[TGT_EEP];
    assign ext_sel   = sel_vec[TGT_EXT];

    assign reg_we    = reg_sel && xfer.we;
    assign io_we     = io_sel  && xfer.we;
    assign ram_we    = ram_sel && xfer.we;
    assign eep_we    = eep_sel && xfer.we;
    assign ext_we    = ext_sel && xfer.we;

    assign reg_wdata = xfer.wdata;
    assign io_wdata  = xfer.wdata;
    assign ram_wdata = xfer.wdata;
    assign eep_wdata = xfer.wdata;
    assign ext_wdata = xfer.wdata;
endmodule

// File: rtl/dsr_checker.sv
module dsr_checker #(
    parameter int SRAM_BYTES = 1024,
    parameter int WAIT_W     = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              ext_layout,
    input logic              eep_map_en,
    input logic [WAIT_W-1:0] ext_wait,
    input logic              cpu_ready,
    input logic              reg_sel,
    input logic              io_sel,
    input logic              ram_sel,
    input logic              eep_sel,
    input logic              ext_sel,
    input logic [15:0]       ext_addr,
    input logic              ext_ack
);
    localparam int C_EXT_BASE = 32'h0060 + SRAM_BYTES;
    localparam int X_EXT_BASE = 32'h2000 + SRAM_BYTES;

    logic [2:0] ext_cyc;
    always_ff @(posedge clk) begin
        if (rst || !ext_sel || cpu_ready) begin
            ext_cyc <= '0;
        end else if (ext_cyc != 3'd7) begin
            ext_cyc <= ext_cyc + 3'd1;
        end
    end

    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reg_sel, io_sel, ram_sel, eep_sel, ext_sel}));

    assert_internal_fast_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_sel || io_sel || ram_sel || eep_sel) |-> cpu_ready);

    assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

    assert_ext_ack_R8: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && ext_sel) |-> ext_ack);

    assert_wait_min_R8: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && ext_sel) |-> (ext_cyc >= 3'(ext_wait)));

    assert_no_regs_wide_R3: assert property (@(posedge clk) disable iff (rst)
        ext_layout |-> !reg_sel);

    assert_ext_shadow_R6: assert property (@(posedge clk) disable iff (rst)
        ext_sel |-> (32'(ext_addr) >= (ext_layout ? X_EXT_BASE : C_EXT_BASE)));

    assert_eep_gate_R4: assert property (@(posedge clk) disable iff (rst)
        eep_sel |-> (eep_map_en && ext_layout));

    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |=> (!cpu_ready && !ext_sel && !ram_sel && !io_sel && !reg_sel && !eep_sel));
endmodule

bind dsr_router dsr_checker #(.SRAM_BYTES(SRAM_BYTES), .WAIT_W(WAIT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .ext_layout (ext_layout),
    .eep_map_en (eep_map_en),
    .ext_wait   (ext_wait),
    .cpu_ready  (cpu_ready),
    .reg_sel    (reg_sel),
    .io_sel     (io_sel),
    .ram_sel    (ram_sel),
    .eep_sel    (eep_sel),
    .ext_sel    (ext_sel),
    .ext_addr   (ext_addr),
    .ext_ack    (ext_ack)
);

// File: tb/dsr_router_tb.sv
module dsr_router_tb_top;
    localparam int SRAM_BYTES = 1024;
    localparam int RAM_AW     = 10;

    // bench target codes
    localparam logic [2:0] T_NONE = 3'd0, T_REG = 3'd1, T_IO = 3'd2,
                           T_RAM = 3'd3, T_EEP = 3'd4, T_EXT = 3'd5;

    typedef struct packed {
        logic        wide;
        logic        een;
        logic [15:0] addr;
        logic [7:0]  data;
        logic [2:0]  tgt;
        logic [11:0] idx;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 16'h0000, 8'hA1, T_REG, 12'h000},  // R1 low edge
        '{1'b0, 1'b0, 16'h001F, 8'hB2, T_REG, 12'h01F},  // R1 high edge
        '{1'b0, 1'b0, 16'h0020, 8'hC3, T_IO,  12'h000},  // R2 io start
        '{1'b0, 1'b0, 16'h005F, 8'hD4, T_IO,  12'h03F},  // R2 io end
        '{1'b0, 1'b0, 16'h0060, 8'hE5, T_RAM, 12'h000},  // R2 sram start
        '{1'b0, 1'b0, 16'h045F, 8'h16, T_RAM, 12'h3FF},  // R2 sram end
        '{1'b0, 1'b0, 16'h0460, 8'h27, T_EXT, 12'h060},  // R6 first external
        '{1'b0, 1'b0, 16'hFFFF, 8'h38, T_EXT, 12'h0FF},  // R6 top
        '{1'b1, 1'b0, 16'h0000, 8'h49, T_IO,  12'h000},  // R3 io start
        '{1'b1, 1'b0, 16'h0FFF, 8'h5A, T_IO,  12'h0FF},  // R3 io end
        '{1'b1, 1'b1, 16'h1000, 8'h6B, T_EEP, 12'h000},  // R4 window start
        '{1'b1, 1'b1, 16'h1FFF, 8'h7C, T_EEP, 12'h0FF},  // R4 window end
        '{1'b1, 1'b0, 16'h1234, 8'h8D, T_NONE,12'h034},  // R4 disabled
        '{1'b1, 1'b0, 16'h2000, 8'h9E, T_RAM, 12'h000},  // R5 sram start
        '{1'b1, 1'b0, 16'h23FF, 8'hAF, T_RAM, 12'h3FF},  // R5 sram end
        '{1'b1, 1'b0, 16'h2400, 8'hB0, T_EXT, 12'h000},  // R6 wide first external
        '{1'b1, 1'b0, 16'h0010, 8'hC1, T_IO,  12'h010}   // R3 no register file
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic              ext_layout = 1'b0, eep_map_en = 1'b0;
    logic [1:0]        ext_wait = 2'd0;
    logic              cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0]       cpu_addr = '0;
    logic [7:0]        cpu_wdata = '0;
    logic              cpu_ready;
    logic [7:0]        cpu_rdata;
    logic              reg_sel, reg_we, io_sel, io_we, ram_sel, ram_we;
    logic              eep_sel, eep_we, ext_sel, ext_we, ext_ack;
    logic [4:0]        reg_idx;
    logic [11:0]       io_addr, eep_addr;
    logic [RAM_AW-1:0] ram_addr;
    logic [15:0]       ext_addr;
    logic [7:0]        reg_wdata, io_wdata, ram_wdata, eep_wdata, ext_wdata;
    logic [7:0]        reg_rdata, io_rdata, ram_rdata, eep_rdata, ext_rdata;

    dsr_router #(.SRAM_BYTES(SRAM_BYTES)) dut_i (.*);

    // simple target memories
    logic [7:0] regs [32];
    logic [7:0] iom  [256];
    logic [7:0] ram  [SRAM_BYTES];
    logic [7:0] eep  [256];
    logic [7:0] ext  [256];

    int ack_delay = 0;
    int ack_cnt   = 0;
    int hits [6];
    logic [15:0] last_ext_addr = '0;

    assign reg_rdata = regs[reg_idx];
    assign io_rdata  = iom[io_addr[7:0]];
    assign ram_rdata = ram[ram_addr];
    assign eep_rdata = eep[eep_addr[7:0]];
    assign ext_rdata = ext[ext_addr[7:0]];
    assign ext_ack   = ext_sel && (ack_cnt >= ack_delay);

    always @(posedge clk) begin
        if (reg_sel && reg_we) regs[reg_idx] <= reg_wdata;
        if (io_sel && io_we)   iom[io_addr[7:0]] <= io_wdata;
        if (ram_sel && ram_we) ram[ram_addr] <= ram_wdata;
        if (eep_sel && eep_we) eep[eep_addr[7:0]] <= eep_wdata;
        if (ext_sel && ext_we && ext_ack) ext[ext_addr[7:0]] <= ext_wdata;
        if (!ext_sel || cpu_ready) ack_cnt <= 0;
        else ack_cnt <= ack_cnt + 1;
        if (cpu_ready) begin
            if (reg_sel) hits[1] <= hits[1] + 1;
            if (io_sel)  hits[2] <= hits[2] + 1;
            if (ram_sel) hits[3] <= hits[3] + 1;
            if (eep_sel) hits[4] <= hits[4] + 1;
            if (ext_sel) begin
                hits[5] <= hits[5] + 1;
                last_ext_addr <= ext_addr;
            end
        end
    end

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_acc(input logic we, input logic [15:0] a, input logic [7:0] d,
                          output logic [7:0] rd, output int cyc);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cyc = 1;
        @(negedge clk);
        cyc = 2;
        while (!cpu_ready && cyc < 50) begin
            @(negedge clk);
            cyc++;
        end
        rd = cpu_rdata;
        cpu_req = 1'b0; cpu_we = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [7:0] mem_at(input logic [2:0] t, input logic [11:0] i);
        case (t)
            T_REG:   return regs[i[4:0]];
            T_IO:    return iom[i[7:0]];
            T_RAM:   return ram[i[9:0]];
            T_EEP:   return eep[i[7:0]];
            T_EXT:   return ext[i[7:0]];
            default: return 8'h00;
        endcase
    endfunction

    function automatic int hit_sum();
        return hits[1] + hits[2] + hits[3] + hits[4] + hits[5];
    endfunction

    initial begin
        for (int i = 0; i < 32; i++) regs[i] = '0;
        for (int i = 0; i < 256; i++) begin iom[i] = '0; eep[i] = '0; ext[i] = '0; end
        for (int i = 0; i < SRAM_BYTES; i++) ram[i] = '0;
        for (int i = 0; i < 6; i++) hits[i] = 0;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int cyc, h0, hx;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!cpu_ready && !reg_sel && !io_sel && !ram_sel && !eep_sel && !ext_sel,
            "R10 reset", int'(cpu_ready), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!cpu_ready && !ext_sel, "R10 after release", int'(cpu_ready), 0);

        // table walk: store then load each vector
        for (int v = 0; v < NV; v++) begin
            ext_layout = VECS[v].wide;
            eep_map_en = VECS[v].een;
            h0 = hit_sum();
            hx = hits[VECS[v].tgt == T_NONE ? 0 : int'(VECS[v].tgt)];
            do_acc(1'b1, VECS[v].addr, VECS[v].data, rd, cyc);
            // R7: two-cycle store
            chk(cyc == 2, "R7 store cycles", cyc, 2);
            if (VECS[v].tgt == T_NONE) begin
                // R4: disabled window strobes nothing and stores nothing
                chk(hit_sum() == h0, "R4 disabled strobe", hit_sum() - h0, 0);
                chk(eep[VECS[v].idx[7:0]] == 8'h00, "R4 disabled write",
                    int'(eep[VECS[v].idx[7:0]]), 0);
            end else begin
                // R1 R2 R3 R5 R6: exactly one strobe on the expected target
                chk(hit_sum() == h0 + 1 && hits[VECS[v].tgt] == hx + 1,
                    "R1/R2/R3/R5/R6 target", hit_sum() - h0, 1);
                // R9: byte landed at the expected offset
                chk(mem_at(VECS[v].tgt, VECS[v].idx) == VECS[v].data, "R9 store offset",
                    int'(mem_at(VECS[v].tgt, VECS[v].idx)), int'(VECS[v].data));
            end
            if (VECS[v].tgt == T_EXT) begin
                chk(last_ext_addr == VECS[v].addr, "R6 ext address",
                    int'(last_ext_addr), int'(VECS[v].addr));
            end
            do_acc(1'b0, VECS[v].addr, 8'h00, rd, cyc);
            chk(cyc == 2, "R7 load cycles", cyc, 2);
            chk(rd == ((VECS[v].tgt == T_NONE) ? 8'h00 : VECS[v].data), "R9 load data",
                int'(rd), int'((VECS[v].tgt == T_NONE) ? 8'h00 : VECS[v].data));
        end

        // R8: wait states with immediate acknowledge
        ext_layout = 1'b0; eep_map_en = 1'b0;
        ext_wait = 2'd3; ack_delay = 0;
        do_acc(1'b1, 16'h8001, 8'h5C, rd, cyc);
        chk(cyc == 5, "R8 wait3 ack0", cyc, 5);
        // R8: acknowledge later than the wait count
        ext_wait = 2'd0; ack_delay = 2;
        do_acc(1'b0, 16'h8001, 8'h00, rd, cyc);
        chk(cyc == 4, "R8 wait0 ack2", cyc, 4);
        chk(rd == 8'h5C, "R8 ext read data", int'(rd), 8'h5C);
        ext_wait = 2'd1; ack_delay = 3;
        do_acc(1'b0, 16'h8001, 8'h00, rd, cyc);
        chk(cyc == 5, "R8 wait1 ack3", cyc, 5);

        // R6: little-endian halfword as two byte stores on the external bus
        ext_wait = 2'd0; ack_delay = 0;
        do_acc(1'b1, 16'h9010, 8'h34, rd, cyc);
        do_acc(1'b1, 16'h9011, 8'h12, rd, cyc);
        chk({ext[8'h11], ext[8'h10]} == 16'h1234, "R6 halfword order",
            int'({ext[8'h11], ext[8'h10]}), 16'h1234);

        // R6: internal address in wide layout keeps ext bus quiet
        ext_layout = 1'b1;
        hx = hits[5];
        do_acc(1'b0, 16'h2100, 8'h00, rd, cyc);
        chk(hits[5] == hx, "R6 shadow", hits[5] - hx, 0);

        // R10: reset mid-stream leaves block idle
        cpu_req = 1'b1; cpu_addr = 16'h2200; cpu_we = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(!cpu_ready && !ram_sel, "R10 reset during request", int'(ram_sel), 0);
        cpu_req = 1'b0; rst = 1'b0;
        @(negedge clk);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule